// File: doc/BRIEF.md
# Flash Program/Erase Status Poller

This block stands in for the status read path of an embedded flash array while an internal program or chip-erase algorithm runs. A small word-organised array sits behind a plain bus with address, write data, read strobe and a decoded command port that can carry program, chip erase or reset. A running algorithm is paced by an internal pulse counter, one pulse per clock.

When the algorithm is idle, a read returns the array word at the address. When it is busy, or locked after a fault, a read returns a status word instead. The status word carries three bits. The polling bit shows the inverse of what is being written. The toggle bit flips on every status read. The limit bit rises once the pulse count passes a parameterised maximum.

A program that would raise a cleared bit back to 1 is treated as misuse. The algorithm then never finishes and the array stays locked. The limit bit eventually latches, and the block stays in this state until a reset command arrives.

Top module: `flash_status_poller`

## Requirements
- R1: After the reset input is released the algorithm is idle, every array word holds all ones, and a read returns the addressed word one clock after the read strobe is sampled.
- R2: A program command (op code 2'b01) whose data sets no bit that the addressed word holds at 0 runs for PROG_PULSES clocks and then stores the data; later reads return the stored word, including its bit 5.
- R3: While a program runs, a read returns status: bit 7 is the inverse of data bit 7, bit 5 (limit) is 0, and bits 4 to 0 are 0.
- R4: Bit 6 of the status word inverts on every status read and starts at 0 after reset input release; reads while idle return array data and leave it unchanged.
- R5: A chip erase command (op code 2'b10) runs for ERASE_PULSES clocks with status bit 7 reading 0, then leaves every word at all ones, so bit 5 of later reads is 1.
- R6: A program whose data sets a bit that the addressed word holds at 0 enters a locked state that never ends on its own; the word is not changed and status bit 7 keeps the inverse of data bit 7.
- R7: In the locked state the limit bit reads 0 until the pulse count exceeds LIMIT_PULSES and reads 1 from then on.
- R8: In the locked state the toggle bit keeps inverting on status reads after the limit has been passed.
- R9: A reset command (op code 2'b11) is accepted at any time, returns the block to idle with the pulse count at zero, and aborts a running program without writing it.
- R10: Program and erase commands that arrive while an algorithm is running or locked have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one algorithm pulse per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 01 program, 10 chip erase, 11 reset |
| addr | input | ADDR_W | Word address for program and read |
| wdata | input | DATA_W | Program data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Registered read data or status word |

## Verification
The bench drives a program that would raise a bit out of a cleared word. A design that missed the check would write the word and go idle, so the later reset would reveal changed data and the limit bit would never rise. It waits past the pulse limit in the locked state and reads twice to catch a limit bit that never sets or a toggle that freezes. It sends erase and program commands during a busy program and while locked; a design that accepted them would wipe or write words that the bench reads back afterwards. A reset sent in the middle of a program catches a design that still commits the aborted write.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_PROG  = 2'b01,
      OP_ERASE = 2'b10,
      OP_RESET = 2'b11
   } fsp_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PROG,
      ST_ERASE,
      ST_LOCK
   } fsp_state_e;

   // status word bit positions (fixed by the read-back format)
   localparam int BIT_POLL   = 7;
   localparam int BIT_TOGGLE = 6;
   localparam int BIT_LIMIT  = 5;
endpackage

// File: rtl/fsp_pulse_timer.sv
module fsp_pulse_timer #(
   parameter int LIMIT_PULSES = 100,
   parameter int CNT_W        = $clog2(LIMIT_PULSES + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             over_limit
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT_PULSES + 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         cnt <= '0;
      else if (run && cnt != SAT)
         cnt <= cnt + 1'b1;
   end

   assign over_limit = (cnt > CNT_W'(LIMIT_PULSES));
endmodule

// File: rtl/fsp_array.sv
module fsp_array #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int WORDS  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              erase,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [WORDS-1:0][DATA_W-1:0] words;

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n || erase)
            word_q <= '1;
         else if (wr_en && wr_addr == ADDR_W'(i))
            word_q <= wr_data;
      end
      assign words[i] = word_q;
   end

   assign rd_data = words[rd_addr];
endmodule

// File: rtl/fsp_status_read.sv
module fsp_status_read
   import flash_status_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              busy,
   input  logic              poll_bit,
   input  logic              over_limit,
   input  logic [DATA_W-1:0] array_word,
   output logic [DATA_W-1:0] rdata
);
   logic              toggle_q;
   logic [DATA_W-1:0] status;

   always_comb begin
      status             = '0;
      status[BIT_POLL]   = poll_bit;
      status[BIT_TOGGLE] = toggle_q;
      status[BIT_LIMIT]  = over_limit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         toggle_q <= 1'b0;
         rdata    <= '0;
      end else if (rd_en) begin
         rdata <= busy ? status : array_word;
         if (busy)
            toggle_q <= ~toggle_q;
      end
   end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
   import flash_status_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 8,
   parameter int PROG_PULSES  = 8,
   parameter int ERASE_PULSES = 64,
   parameter int LIMIT_PULSES = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata
);
   localparam int CNT_W = $clog2(LIMIT_PULSES + 2);
   localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_PULSES - 1);
   localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_PULSES - 1);

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold the status bits");
   end
   if (PROG_PULSES < 1 || ERASE_PULSES < 1) begin : g_bad_pulses
      $error("pulse counts must be positive");
   end
   if (PROG_PULSES >= LIMIT_PULSES || ERASE_PULSES >= LIMIT_PULSES) begin : g_bad_limit
      $error("normal algorithms must end below the limit");
   end

   fsp_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  pulse_cnt;
   logic              over_limit;
   logic [DATA_W-1:0] cur_word;

   logic cmd_reset, start_prog, start_erase, raises_bit, done, commit;

   assign cmd_reset   = cmd_valid && fsp_op_e'(cmd_op) == OP_RESET;
   assign start_prog  = cmd_valid && fsp_op_e'(cmd_op) == OP_PROG  && state_q == ST_IDLE;
   assign start_erase = cmd_valid && fsp_op_e'(cmd_op) == OP_ERASE && state_q == ST_IDLE;
   assign raises_bit  = |(wdata & ~cur_word);
   assign done        = (state_q == ST_PROG  && pulse_cnt == PROG_LAST) ||
                        (state_q == ST_ERASE && pulse_cnt == ERASE_LAST);
   assign commit      = done && !cmd_reset;

   always_ff @(posedge clk) begin
      if (!rst_n || cmd_reset) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_prog)
                  state_q <= raises_bit ? ST_LOCK : ST_PROG;
               else if (start_erase)
                  state_q <= ST_ERASE;
            end
            ST_PROG, ST_ERASE: if (done) state_q <= ST_IDLE;
            ST_LOCK: state_q <= ST_LOCK;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (start_prog) begin
         addr_q <= addr;
         data_q <= wdata;
      end
   end

   fsp_pulse_timer #(
      .LIMIT_PULSES(LIMIT_PULSES),
      .CNT_W       (CNT_W)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (cmd_reset || start_prog || start_erase),
      .run       (state_q != ST_IDLE),
      .cnt       (pulse_cnt),
      .over_limit(over_limit)
   );

   fsp_array #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) i_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (commit && state_q == ST_PROG),
      .wr_addr(addr_q),
      .wr_data(data_q),
      .erase  (commit && state_q == ST_ERASE),
      .rd_addr(addr),
      .rd_data(cur_word)
   );

   fsp_status_read #(
      .DATA_W(DATA_W)
   ) i_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .busy      (state_q != ST_IDLE),
      .poll_bit  (state_q == ST_ERASE ? 1'b0 : ~data_q[BIT_POLL]),
      .over_limit(over_limit),
      .array_word(cur_word),
      .rdata     (rdata)
   );
endmodule

// File: rtl/flash_status_poller_chk.sv
module flash_status_poller_chk
   import flash_status_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [1:0]       cmd_op,
   input logic             rd_en,
   input logic             rdata_tog,
   input fsp_state_e       state,
   input logic [CNT_W-1:0] cnt,
   input logic             over_limit
);
   logic is_reset, is_start;
   assign is_reset = cmd_valid && fsp_op_e'(cmd_op) == OP_RESET;
   assign is_start = cmd_valid && (fsp_op_e'(cmd_op) == OP_PROG || fsp_op_e'(cmd_op) == OP_ERASE);

   // R6: locked state persists until a reset command
   a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOCK && !is_reset) |=> state == ST_LOCK);

   // R9: reset command yields idle with a cleared pulse count
   a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      is_reset |=> (state == ST_IDLE && cnt == '0));

   // R3: limit never flagged during a normal program or erase
   a_r3_no_limit_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROG || state == ST_ERASE) |-> !over_limit);

   // R4: back-to-back status reads alternate the toggle bit
   a_r4_toggle_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && state != ST_IDLE) ##1 (rd_en && state != ST_IDLE) |=> rdata_tog != $past(rdata_tog));

   // R7: limit flag stays set while locked
   a_r7_limit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOCK && over_limit && !is_reset) |=> over_limit);

   // R10: a start request while busy does not restart the pulse count
   a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && is_start && !is_reset) |=> cnt != '0);
endmodule

bind flash_status_poller flash_status_poller_chk #(
   .CNT_W(CNT_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .rd_en     (rd_en),
   .rdata_tog (rdata[6]),
   .state     (state_q),
   .cnt       (pulse_cnt),
   .over_limit(over_limit)
);

// File: tb/test_flash_status_poller.sv
module test_flash_status_poller;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int LIMIT  = 100;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = 2'b00;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic              rd_en = 1'b0;
   logic [DATA_W-1:0] rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic tog = 1'b0;
   logic rd_seen = 1'b0;

   typedef struct {
      logic [DATA_W-1:0] exp;
      string             tag;
   } item_t;
   item_t sb[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   flash_status_poller #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PROG_PULSES(8), .ERASE_PULSES(64), .LIMIT_PULSES(LIMIT)
   ) i_flash_status_poller (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .addr(addr), .wdata(wdata), .rd_en(rd_en), .rdata(rdata)
   );

   // monitor: compare each read result against the scoreboard head
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen) begin
         n_cmp++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected read: actual %h expected none", rdata);
         end else begin
            item_t it;
            it = sb.pop_front();
            if (rdata !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   function automatic logic [7:0] st(logic poll, logic lim);
      logic [7:0] v;
      v = {poll, tog, lim, 5'b0};
      tog = ~tog;
      return v;
   endfunction

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cmd(logic [1:0] op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; addr = a; wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
   endtask

   task automatic rd(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] e, string tag);
      item_t it;
      @(negedge clk);
      it.exp = e; it.tag = tag;
      sb.push_back(it);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: erased array after reset
      rd(4'd0,  8'hFF, "R1 word0 erased");
      rd(4'd15, 8'hFF, "R1 word15 erased");

      // R2 R3 R4: normal program with status reads
      cmd(2'b01, 4'd2, 8'h3C);
      rd(4'd2, st(1'b1, 1'b0), "R3 program status");
      rd(4'd2, st(1'b1, 1'b0), "R4 toggle during program");
      idle(12);
      rd(4'd2, 8'h3C, "R2 stored word");
      rd(4'd0, 8'hFF, "R2 neighbour untouched");

      // R10: erase during a running program is ignored
      cmd(2'b01, 4'd7, 8'h55);
      cmd(2'b10, 4'd0, 8'h00);
      idle(80);
      rd(4'd7, 8'h55, "R10 erase ignored while busy");
      rd(4'd2, 8'h3C, "R10 other word kept");

      // R5: chip erase
      cmd(2'b10, 4'd0, 8'h00);
      rd(4'd0, st(1'b0, 1'b0), "R5 erase status");
      idle(70);
      rd(4'd7, 8'hFF, "R5 erased word7");
      rd(4'd2, 8'hFF, "R5 erased word2 bit5 set");

      // R6 R7 R8: zero-to-one program locks
      cmd(2'b01, 4'd4, 8'h30);
      idle(12);
      cmd(2'b01, 4'd4, 8'hB0);
      rd(4'd4, st(1'b0, 1'b0), "R6 locked status");
      idle(20);
      rd(4'd4, st(1'b0, 1'b0), "R7 limit low early");
      cmd(2'b01, 4'd5, 8'h11);
      idle(LIMIT);
      rd(4'd4, st(1'b0, 1'b1), "R7 limit set");
      rd(4'd4, st(1'b0, 1'b1), "R8 toggle past limit");

      // R9: reset command leaves lock
      cmd(2'b11, 4'd0, 8'h00);
      rd(4'd4, 8'h30, "R6 locked word unchanged");
      rd(4'd5, 8'hFF, "R10 program ignored while locked");

      // R9: reset aborts a running program, next program is normal
      cmd(2'b01, 4'd9, 8'h00);
      cmd(2'b11, 4'd0, 8'h00);
      rd(4'd9, 8'hFF, "R9 aborted program not written");
      cmd(2'b01, 4'd9, 8'hA5);
      rd(4'd9, st(1'b0, 1'b0), "R9 fresh program limit low");
      idle(12);
      rd(4'd9, 8'hA5, "R9 program after reset stored");
      idle(3);

      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule